// File: doc/BRIEF.md
# Write-Engine Status Register

This block holds the status byte that an internal program/erase engine exposes to a host on a parallel bus. It has a ready bit, which the engine clears when an operation starts and sets again when it finishes. It also has two failure flags, one for program and one for erase. Once either flag is set, it stays set until the host sends an explicit clear command. While either flag is set, the block refuses new operation starts and raises an inhibit output, which the command logic uses to block page program and chip erase.

The host never sees the live value. A read-start strobe marks the moment a read cycle begins, which is the later of the two enable falling edges, and the value present at that moment is copied into a snapshot register. The snapshot stays frozen until the next read starts, so a status word cannot change in the middle of a bus read. The byte view always carries the snapshot. The 16-bit view puts zeros in the upper byte, and a lane-enable output tells the pad logic whether to drive the upper byte (word mode) or leave it floating (byte mode).

Top module: `wsm_status_reg`

## Requirements
- R1: The ready bit is bit 7, where 1 means ready. It is 1 after reset. An accepted start pulse clears it at the next clock edge. A program-done or erase-done pulse sets it at the next edge. If a start and a done arrive in the same cycle, the start wins.
- R2: Bits 6, 3, 2, 1 and 0 of the status byte always read 0.
- R3: The 16-bit view has 0x00 in bits 15:8 and the status byte in bits 7:0. The upper-lane enable output equals the word-mode input (1 means word mode).
- R4: A program-fail pulse sets bit 4 and an erase-fail pulse sets bit 5. Neither start nor done pulses clear these bits.
- R5: The inhibit output is high whenever bit 4 or bit 5 is set. A start pulse that arrives while inhibit is high is ignored, and the ready bit keeps its value.
- R6: A read-start pulse copies the status value held before that clock edge into the output at that edge. Without a read-start pulse, the output holds its value.
- R7: After reset, the status value is 0x80. A clear pulse resets bits 4 and 5 at the next edge, so a ready engine then reads 0x80.
- R8: If a fail pulse and a clear pulse arrive in the same cycle, the fail flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start_i | input | 1 | Pulse: engine begins a program or erase |
| pgm_done_i | input | 1 | Pulse: program operation finished |
| ers_done_i | input | 1 | Pulse: erase operation finished |
| pgm_fail_i | input | 1 | Pulse: program operation failed |
| ers_fail_i | input | 1 | Pulse: erase operation failed |
| clr_stat_i | input | 1 | Pulse: clear-status command decoded |
| rd_start_i | input | 1 | Pulse: a host read cycle begins |
| word_mode_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| status_o | output | 8 | Snapshot status byte |
| status_word_o | output | 16 | 16-bit view of the snapshot |
| upper_lane_en_o | output | 1 | Drive enable for bits 15:8 |
| inhibit_o | output | 1 | A fail flag is set; new operations are blocked |

## Verification
The assertions check the following on every cycle: the reserved bits stay at zero, the upper byte stays at zero, the snapshot holds still between read strobes, the fail flags are sticky and a fail pulse beats a same-cycle clear, a clear with no competing fail drops inhibit, and a refused start leaves ready unchanged. Some behaviour can only be seen in the bench scenarios. These include the exact value a read captures when a read coincides with a start, the ordering of ready against done and start pulses, and the full byte the host sees after a sequence of fail, clear and retry. A cycle-by-cycle reference model is compared against those scenarios.

// File: rtl/wsm_status_pkg.sv
package wsm_status_pkg;
  localparam int STAT_W    = 8;
  localparam int BIT_READY = 7;
  localparam int BIT_EFAIL = 5;
  localparam int BIT_PFAIL = 4;
  localparam int NUM_FAIL  = 2;
  localparam int FAIL_PGM  = 0;
  localparam int FAIL_ERS  = 1;

  typedef struct packed {
    logic ready;
    logic efail;
    logic pfail;
  } stat_fields_t;

  function automatic logic [STAT_W-1:0] pack_status(input stat_fields_t f);
    logic [STAT_W-1:0] r;
    r            = '0;
    r[BIT_READY] = f.ready;
    r[BIT_EFAIL] = f.efail;
    r[BIT_PFAIL] = f.pfail;
    return r;
  endfunction
endpackage

// File: rtl/wsm_rst_sync.sv
module wsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wsm_ready_track.sv
module wsm_ready_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok_i,
  input  logic done_i,
  output logic ready_o
);
  logic ready_q, ready_d, ready_en;

  always_comb begin
    ready_en = start_ok_i | done_i;
    ready_d  = start_ok_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ready_q <= 1'b1;
    else if (ready_en) ready_q <= ready_d;
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/wsm_fail_flags.sv
module wsm_fail_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q, flag_d, flag_en;

    always_comb begin
      flag_en = set_i[i] | clr_i;
      flag_d  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flag_o[i] = flag_q;
  end
endmodule

// File: rtl/wsm_status_snap.sv
module wsm_status_snap #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= RST_VAL;
    else if (cap_i) snap_q <= live_i;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/wsm_status_reg.sv
module wsm_status_reg
  import wsm_status_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start_i,
  input  logic              pgm_done_i,
  input  logic              ers_done_i,
  input  logic              pgm_fail_i,
  input  logic              ers_fail_i,
  input  logic              clr_stat_i,
  input  logic              rd_start_i,
  input  logic              word_mode_i,
  output logic [STAT_W-1:0] status_o,
  output logic [WORD_W-1:0] status_word_o,
  output logic              upper_lane_en_o,
  output logic              inhibit_o
);
  localparam int UPPER_W = WORD_W - STAT_W;
  localparam stat_fields_t RST_FIELDS = '{ready: 1'b1, efail: 1'b0, pfail: 1'b0};

  logic                rst_int_n;
  logic [NUM_FAIL-1:0] fail_set, fail_flags;
  logic                live_ready, start_ok, any_done;
  stat_fields_t        live_fields;
  logic [STAT_W-1:0]   live_byte, snap_byte;

  wsm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  always_comb begin
    fail_set           = '0;
    fail_set[FAIL_PGM] = pgm_fail_i;
    fail_set[FAIL_ERS] = ers_fail_i;
    start_ok           = op_start_i & ~(|fail_flags);
    any_done           = pgm_done_i | ers_done_i;
  end

  wsm_fail_flags #(.N(NUM_FAIL)) u_fail (
    .clk(clk), .rst_n(rst_int_n), .set_i(fail_set),
    .clr_i(clr_stat_i), .flag_o(fail_flags)
  );

  wsm_ready_track u_ready (
    .clk(clk), .rst_n(rst_int_n), .start_ok_i(start_ok),
    .done_i(any_done), .ready_o(live_ready)
  );

  always_comb begin
    live_fields.ready = live_ready;
    live_fields.efail = fail_flags[FAIL_ERS];
    live_fields.pfail = fail_flags[FAIL_PGM];
    live_byte         = pack_status(live_fields);
  end

  wsm_status_snap #(.W(STAT_W), .RST_VAL(pack_status(RST_FIELDS))) u_snap (
    .clk(clk), .rst_n(rst_int_n), .cap_i(rd_start_i),
    .live_i(live_byte), .snap_o(snap_byte)
  );

  assign status_o        = snap_byte;
  assign status_word_o   = {{UPPER_W{1'b0}}, snap_byte};
  assign upper_lane_en_o = word_mode_i;
  assign inhibit_o       = |fail_flags;
endmodule

// File: rtl/wsm_status_chk.sv
module wsm_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_start_i,
  input logic        pgm_fail_i,
  input logic        ers_fail_i,
  input logic        clr_stat_i,
  input logic        rd_start_i,
  input logic [7:0]  status_o,
  input logic [15:0] status_word_o,
  input logic        inhibit_o,
  input logic        live_ready
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] == 1'b0) && (status_o[3:0] == 4'h0));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_word_o[15:8] == 8'h00);

  assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_o && !clr_stat_i) |=> inhibit_o);

  assert_refused_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_o && op_start_i && live_ready) |=> live_ready);

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start_i |=> $stable(status_o));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat_i && !pgm_fail_i && !ers_fail_i) |=> !inhibit_o);

  assert_fail_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_fail_i || ers_fail_i) |=> inhibit_o);
endmodule

bind wsm_status_reg wsm_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_start_i(op_start_i), .pgm_fail_i(pgm_fail_i),
  .ers_fail_i(ers_fail_i), .clr_stat_i(clr_stat_i), .rd_start_i(rd_start_i),
  .status_o(status_o), .status_word_o(status_word_o), .inhibit_o(inhibit_o),
  .live_ready(live_ready)
);

// File: tb/wsm_status_reg_bench.sv
module wsm_status_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, pdone = 0, edone = 0, pfail = 0, efail = 0, clr = 0, rd = 0, wmode = 0;
  logic [7:0]  st;
  logic [15:0] stw;
  logic        upen, inh;

  int errors = 0;
  int checks = 0;
  bit done_run = 0;

  always #5 clk = ~clk;

  wsm_status_reg u_wsm_status_reg (
    .clk(clk), .rst_n(rst_n), .op_start_i(start), .pgm_done_i(pdone),
    .ers_done_i(edone), .pgm_fail_i(pfail), .ers_fail_i(efail),
    .clr_stat_i(clr), .rd_start_i(rd), .word_mode_i(wmode),
    .status_o(st), .status_word_o(stw), .upper_lane_en_o(upen), .inhibit_o(inh)
  );

  // behavioural reference model
  int m_ready = 1, m_pf = 0, m_ef = 0, m_snap = 'h80;

  function automatic int live_val();
    return m_ready * 128 + m_ef * 32 + m_pf * 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 1; m_pf = 0; m_ef = 0; m_snap = 'h80;
    end else begin
      int blocked;
      blocked = m_pf | m_ef;
      if (rd) m_snap = live_val();
      if (start && !blocked) m_ready = 0;
      else if (pdone || edone) m_ready = 1;
      if (pfail) m_pf = 1; else if (clr) m_pf = 0;
      if (efail) m_ef = 1; else if (clr) m_ef = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #3;
    if (rst_n && !done_run) begin
      check("R6 status vs model", st, m_snap);
      check("R3 word view vs model", stw, m_snap);
      check("R3 lane enable", upen, wmode);
      check("R5 inhibit vs model", inh, m_pf | m_ef);
    end
  end

  task automatic cyc(input bit s, pd, ed, pf, ef, c, r);
    start = s; pdone = pd; edone = ed; pfail = pf; efail = ef; clr = c; rd = r;
    @(negedge clk);
    start = 0; pdone = 0; edone = 0; pfail = 0; efail = 0; clr = 0; rd = 0;
  endtask

  task automatic rdcyc();
    cyc(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic finish_run();
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset status", st, 'h80);
    check("R7 reset inhibit", inh, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cyc(1, 0, 0, 0, 0, 0, 0); rdcyc();
    check("R1 busy after start", st, 'h00);
    cyc(0, 1, 0, 0, 0, 0, 0); rdcyc();
    check("R1 ready after program done", st, 'h80);
    cyc(1, 0, 0, 0, 0, 0, 0); cyc(1, 0, 1, 0, 0, 0, 0); rdcyc();
    check("R1 start beats done", st, 'h00);
    cyc(0, 0, 1, 0, 0, 0, 0); rdcyc();
    check("R1 ready after erase done", st, 'h80);

    cyc(1, 0, 0, 0, 0, 0, 0); cyc(0, 1, 0, 1, 0, 0, 0); rdcyc();
    check("R4 program fail bit", st, 'h90);
    check("R5 inhibit raised", inh, 1);
    cyc(1, 0, 0, 0, 0, 0, 0); rdcyc();
    check("R5 start refused while inhibited", st, 'h90);
    cyc(0, 1, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1, 0, 0); rdcyc();
    check("R4 erase fail bit added, done keeps flags", st, 'hB0);
    check("R2 reserved bits zero", st & 'h4F, 0);
    check("R3 upper byte zero", stw[15:8], 0);
    cyc(0, 0, 0, 0, 0, 1, 0); rdcyc();
    check("R7 clear gives 0x80", st, 'h80);
    check("R7 inhibit dropped", inh, 0);

    cyc(0, 0, 0, 0, 1, 1, 0); rdcyc();
    check("R8 fail beats clear", st, 'hA0);
    cyc(0, 0, 0, 1, 0, 1, 0); rdcyc();
    check("R8 program fail beats clear, erase flag cleared", st, 'h90);
    cyc(0, 0, 0, 0, 0, 1, 0);

    rdcyc();
    cyc(1, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R6 snapshot held without read", st, 'h80);
    rdcyc();
    check("R6 new read sees busy", st, 'h00);
    cyc(0, 1, 0, 0, 0, 0, 1);
    check("R6 read with done captures old value", st, 'h00);
    rdcyc();
    check("R6 following read sees ready", st, 'h80);

    wmode = 1;
    @(negedge clk);
    check("R3 upper lane on in word mode", upen, 1);
    check("R3 word view", stw, 'h0080);
    wmode = 0;
    @(negedge clk);
    check("R3 upper lane off in byte mode", upen, 0);

    for (int i = 0; i < 40; i++) begin
      cyc(i % 3 == 0, i % 5 == 1, i % 7 == 2, i % 11 == 3, i % 13 == 4, i % 4 == 1, i % 2 == 0);
      wmode = (i % 6) > 2;
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule